// File: doc/BRIEF.md
# Tenth-Second On-Delay Countdown Timer

This block is an on-delay timer that counts down in steps of 0.1 s. A separate tick source supplies a one-cycle strobe every tenth of a second. While the timer input (`run`) is low, the present value is continuously reloaded from the set value and the completion flag is held low. Once `run` is high, each tick lowers the present value by one. When the present value reaches zero, the completion flag rises. It then stays high, with the present value held at zero, for as long as `run` stays high.

The 32-bit set and present values are read either as eight packed decimal digits (BCD mode) or as plain binary (binary mode). In BCD mode the decrement borrows from digit to digit. Also in BCD mode, a combinational error flag reports any nibble above 9 in either value. While that flag is high, ticks are ignored.

A timed-out timer can be restarted in two ways: drop `run` and raise it again, or write a nonzero present value through the write port. The completion flag can also be forced high or low while the timer runs, and forcing it leaves the present value untouched.

Top module: `tenth_delay_timer`

## Requirements
- R1: During and right after reset, `pv` is 0, `done` is 0, and `err` is 0 (BCD mode with a valid set value).
- R2: On each clock edge with `run` low, `pv` takes `preset` and `done` goes to 0. Both take effect one cycle later.
- R3: With `run` high, no write, `err` low and `pv` nonzero, a clock edge with `tick` high lowers `pv` by one. An edge with `tick` low leaves `pv` unchanged.
- R4: In BCD mode (`bcd_mode`=1, nibble 0 = least significant digit), the decrement turns a 0 digit into 9 and borrows from the next higher nibble. For example, 0x10000000 becomes 0x09999999 and 0x10 becomes 0x09.
- R5: In binary mode (`bcd_mode`=0), the decrement is a plain 32-bit subtract by one. Any 32-bit value, including 0xFFFFFFFF, loads and counts.
- R6: The tick that brings `pv` to zero sets `done` on the same edge. Later ticks keep `pv` at zero and `done` high, so `pv` never wraps below zero.
- R7: After a timeout, lowering `run` and raising it again reloads `preset`, clears `done` and restarts counting.
- R8: With `run` high, a `pv_wr` edge loads `pv_wdata` into `pv` and has priority over a tick. `done` becomes 1 if the written value is zero and 0 otherwise, so a nonzero write restarts counting.
- R9: In BCD mode, `err` is high in the same cycle whenever any nibble of `pv` or `preset` is above 9. In binary mode, `err` is always 0.
- R10: While `err` is high, ticks change neither `pv` nor `done`.
- R11: With `run` high, `done_force_hi` sets `done` and `done_force_lo` clears it on the next edge, and `done_force_hi` wins if both are high. `pv` is unchanged by forcing. Both force inputs are ignored while `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 0.1 s strobe |
| run | input | 1 | Timer input; high lets the timer count |
| preset | input | 32 | Set value |
| bcd_mode | input | 1 | 1 = packed decimal digits, 0 = binary |
| pv_wr | input | 1 | Present-value write strobe |
| pv_wdata | input | 32 | Present-value write data |
| done_force_hi | input | 1 | Force completion flag high |
| done_force_lo | input | 1 | Force completion flag low |
| pv | output | 32 | Present value |
| done | output | 1 | Completion flag |
| err | output | 1 | Invalid-digit error flag |

## Verification
Counting is tried in several ways:
- Single-digit borrows (0x10 to 0x09) and a full seven-digit borrow chain (0x10000000 to 0x09999999) show that each digit's borrow stage works.
- Binary counts from 0x100 and from 0xFFFFFFFF show the plain subtract path apart from the decimal one.
- Ticks at zero, writes of zero and nonzero values, and a low-then-high `run` cycle separate holding at zero from restarting.
- Invalid nibbles are placed first in the present value and then in the set value, and each is shown to freeze counting. A mode switch then shows that the error check depends on the mode.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
    localparam int unsigned NIB_W = 4;
    localparam logic [NIB_W-1:0] MAX_DIGIT = 4'd9;

    typedef enum logic {
        MODE_BIN = 1'b0,
        MODE_BCD = 1'b1
    } count_mode_e;
endpackage

// File: rtl/tdt_bcd_dec.sv
module tdt_bcd_dec
    import tdt_pkg::*;
#(
    parameter int unsigned N_DIGITS = 8,
    localparam int unsigned VAL_W = N_DIGITS * NIB_W
) (
    input  logic [VAL_W-1:0] val_in,
    output logic [VAL_W-1:0] val_out
);
    logic [N_DIGITS:0] borrow;
    assign borrow[0] = 1'b1;

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
        logic [NIB_W-1:0] dig;
        assign dig = val_in[g*NIB_W +: NIB_W];
        always_comb begin
            if (!borrow[g]) begin
                val_out[g*NIB_W +: NIB_W] = dig;
                borrow[g+1] = 1'b0;
            end else if (dig == '0) begin
                val_out[g*NIB_W +: NIB_W] = MAX_DIGIT;
                borrow[g+1] = 1'b1;
            end else begin
                val_out[g*NIB_W +: NIB_W] = dig - 1'b1;
                borrow[g+1] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tdt_nib_check.sv
module tdt_nib_check
    import tdt_pkg::*;
#(
    parameter int unsigned N_DIGITS = 8,
    localparam int unsigned VAL_W = N_DIGITS * NIB_W
) (
    input  logic [VAL_W-1:0] val_in,
    output logic             bad
);
    logic [N_DIGITS-1:0] bad_vec;

    for (genvar g = 0; g < N_DIGITS; g++) begin : g_nib
        assign bad_vec[g] = (val_in[g*NIB_W +: NIB_W] > MAX_DIGIT);
    end

    assign bad = |bad_vec;
endmodule

// File: rtl/tenth_delay_timer.sv
module tenth_delay_timer
    import tdt_pkg::*;
#(
    parameter int unsigned N_DIGITS = 8,
    localparam int unsigned VAL_W = N_DIGITS * NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic [VAL_W-1:0] preset,
    input  logic             bcd_mode,
    input  logic             pv_wr,
    input  logic [VAL_W-1:0] pv_wdata,
    input  logic             done_force_hi,
    input  logic             done_force_lo,
    output logic [VAL_W-1:0] pv,
    output logic             done,
    output logic             err
);
    typedef struct packed {
        logic [VAL_W-1:0] pv;
        logic             done;
    } state_t;

    state_t state_d, state_q;

    count_mode_e      mode;
    logic [VAL_W-1:0] bcd_next;
    logic [VAL_W-1:0] bin_next;
    logic [VAL_W-1:0] dec_val;
    logic             pv_bad;
    logic             preset_bad;

    assign mode = count_mode_e'(bcd_mode);

    tdt_bcd_dec #(.N_DIGITS(N_DIGITS)) u_dec (
        .val_in  (state_q.pv),
        .val_out (bcd_next)
    );

    tdt_nib_check #(.N_DIGITS(N_DIGITS)) u_chk_pv (
        .val_in (state_q.pv),
        .bad    (pv_bad)
    );

    tdt_nib_check #(.N_DIGITS(N_DIGITS)) u_chk_sv (
        .val_in (preset),
        .bad    (preset_bad)
    );

    assign bin_next = state_q.pv - 1'b1;
    assign dec_val  = (mode == MODE_BCD) ? bcd_next : bin_next;
    assign err      = (mode == MODE_BCD) && (pv_bad || preset_bad);

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d.pv   = preset;
            state_d.done = 1'b0;
        end else begin
            if (pv_wr) begin
                state_d.pv   = pv_wdata;
                state_d.done = (pv_wdata == '0);
            end else if (tick && !err) begin
                if (state_q.pv != '0) begin
                    state_d.pv   = dec_val;
                    state_d.done = (dec_val == '0);
                end else begin
                    state_d.done = 1'b1;
                end
            end
            if (done_force_hi) begin
                state_d.done = 1'b1;
            end else if (done_force_lo) begin
                state_d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pv   = state_q.pv;
    assign done = state_q.done;
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker #(
    parameter int unsigned VAL_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             run,
    input logic [VAL_W-1:0] preset,
    input logic             bcd_mode,
    input logic             pv_wr,
    input logic             done_force_hi,
    input logic             done_force_lo,
    input logic [VAL_W-1:0] pv,
    input logic             done,
    input logic             err
);
    a_r2_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pv == $past(preset)) && !done);

    a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick && !pv_wr |=> pv == $past(pv));

    a_r5_bin_step: assert property (@(posedge clk) disable iff (!rst_n)
        run && tick && !pv_wr && !bcd_mode && (pv != '0) |=> pv == ($past(pv) - 1'b1));

    a_r6_reach_zero: assert property (@(posedge clk) disable iff (!rst_n)
        run && tick && !pv_wr && !err && (pv == 1) && !done_force_lo |=> (pv == '0) && done);

    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        run && (pv == '0) && !pv_wr |=> pv == '0);

    a_r9_bin_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        !bcd_mode |-> !err);

    a_r10_err_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        run && err && !pv_wr |=> pv == $past(pv));

    a_r11_force_hi: assert property (@(posedge clk) disable iff (!rst_n)
        run && done_force_hi && !pv_wr && !tick |=> done && (pv == $past(pv)));
endmodule

bind tenth_delay_timer tdt_checker #(.VAL_W(VAL_W)) u_tdt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .run           (run),
    .preset        (preset),
    .bcd_mode      (bcd_mode),
    .pv_wr         (pv_wr),
    .done_force_hi (done_force_hi),
    .done_force_lo (done_force_lo),
    .pv            (pv),
    .done          (done),
    .err           (err)
);

// File: tb/sim_tenth_delay_timer.sv
module sim_tenth_delay_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        run = 1'b0;
    logic [31:0] preset = 32'h0000_0010;
    logic        bcd_mode = 1'b1;
    logic        pv_wr = 1'b0;
    logic [31:0] pv_wdata = '0;
    logic        done_force_hi = 1'b0;
    logic        done_force_lo = 1'b0;
    logic [31:0] pv;
    logic        done;
    logic        err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct packed {
        logic [31:0] pv;
        logic        done;
        logic        err;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    tenth_delay_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .preset(preset),
        .bcd_mode(bcd_mode), .pv_wr(pv_wr), .pv_wdata(pv_wdata),
        .done_force_hi(done_force_hi), .done_force_lo(done_force_lo),
        .pv(pv), .done(done), .err(err)
    );

    // monitor: compares each expected item just after the edge it describes
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (pv !== e.pv || done !== e.done || err !== e.err) begin
                errors++;
                $display("FAIL %s: pv=%h done=%b err=%b expected pv=%h done=%b err=%b",
                         t, pv, done, err, e.pv, e.done, e.err);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // driver: inputs already set at a falling edge; push expectation for next edge
    task automatic step(input string tag, input logic [31:0] e_pv, input logic e_done,
                        input logic e_err);
        exp_t e;
        e.pv = e_pv; e.done = e_done; e.err = e_err;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        tick = 1'b0; pv_wr = 1'b0; done_force_hi = 1'b0; done_force_lo = 1'b0;
    endtask

    task automatic wr(input logic [31:0] d);
        pv_wr = 1'b1; pv_wdata = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (pv !== 32'h0 || done !== 1'b0 || err !== 1'b0) begin
            errors++;
            $display("FAIL R1: pv=%h done=%b err=%b expected pv=0 done=0 err=0", pv, done, err);
        end
        rst_n = 1'b1;
        step("R2 idle load", 32'h10, 0, 0);
        run = 1'b1;
        step("R3 no tick hold", 32'h10, 0, 0);
        tick = 1; step("R4 borrow 10->09", 32'h09, 0, 0);
        tick = 1; step("R3 tick 09->08", 32'h08, 0, 0);
        step("R3 no tick", 32'h08, 0, 0);
        wr(32'h1); step("R8 write nonzero", 32'h01, 0, 0);
        tick = 1; step("R6 reach zero", 32'h0, 1, 0);
        tick = 1; step("R6 stays zero", 32'h0, 1, 0);
        done_force_lo = 1; step("R11 force lo", 32'h0, 0, 0);
        done_force_hi = 1; step("R11 force hi", 32'h0, 1, 0);
        done_force_hi = 1; done_force_lo = 1; step("R11 hi wins", 32'h0, 1, 0);
        run = 0; step("R7 run low reload", 32'h10, 0, 0);
        done_force_hi = 1; step("R11 ignored run low", 32'h10, 0, 0);
        run = 1; tick = 1; step("R7 restart count", 32'h09, 0, 0);
        wr(32'h1000_0000); step("R8 write", 32'h1000_0000, 0, 0);
        tick = 1; step("R4 long borrow", 32'h0999_9999, 0, 0);
        wr(32'h0); step("R8 write zero", 32'h0, 1, 0);
        wr(32'h0000_000A); step("R9 pv bad nibble", 32'hA, 0, 1);
        tick = 1; step("R10 err freezes", 32'hA, 0, 1);
        done_force_hi = 1; step("R11 force with err", 32'hA, 1, 1);
        preset = 32'h0000_00F0; run = 0; step("R9 preset bad", 32'hF0, 0, 1);
        preset = 32'h0000_001F; run = 1; wr(32'h5); step("R9 preset bad pv ok", 32'h5, 0, 1);
        tick = 1; step("R10 preset err freezes", 32'h5, 0, 1);
        bcd_mode = 0; tick = 1; step("R9 bin no err", 32'h4, 0, 0);
        wr(32'h100); step("R5 write", 32'h100, 0, 0);
        tick = 1; step("R5 bin 100->FF", 32'hFF, 0, 0);
        wr(32'hFFFF_FFFF); step("R5 write max", 32'hFFFF_FFFF, 0, 0);
        tick = 1; step("R5 bin max step", 32'hFFFF_FFFE, 0, 0);
        preset = 32'hFFFF_FFFF; run = 0; step("R5 full range load", 32'hFFFF_FFFF, 0, 0);
        bcd_mode = 1; preset = 32'h9999_9999; step("R9 max bcd valid", 32'h9999_9999, 0, 0);
        run = 1; tick = 1; step("R4 top digits", 32'h9999_9998, 0, 0);
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule